// File: doc/BRIEF.md
# Receive Ring Page Manager

This block stores received frames into a circular buffer held in local memory. The buffer is divided into 256-byte pages, and the host sets the ring's first page and its end page. A frame arrives as a byte stream framed by a start strobe and an end strobe. The frame's receive status is supplied on the end strobe. The block writes the payload bytes first, beginning 4 bytes into the current page and leaving a header slot there. It then fills in the header and moves its current-page pointer to the page after the frame.

The host frees space by moving a boundary page forward behind the frames it has consumed. Whenever the writer claims a new page and that page equals the boundary, the ring is full. In that case the block raises a one-cycle overwrite-warning pulse and drops the frame: no header is written and the current page does not move. The host polls the current page to find committed frames. The ring holds no frames when the host's next-read page equals the current page.

Top module: `rxring_top`

## Requirements
- R1: After reset the current page equals the parameter RST_START, the boundary is RST_STOP-1, and neither a memory write nor an overwrite warning is issued.
- R2: A configuration write with select 0 sets the ring start page and also loads the current page with that value. Select 1 sets the end page (exclusive) and sets the boundary to one less than it. Select 2 sets the boundary page.
- R3: Payload byte k of a frame is written at in-page offset (4+k) mod 256. It lands in the page reached by advancing the starting current page floor((4+k)/256) times, where the page after end-1 is the start page.
- R4: After the end strobe, the header is written in four consecutive cycles to offsets 0,1,2,3 of the frame's first page. The bytes are, in order: the status sampled with the end strobe, the next-page link, the low length byte, and the high length byte.
- R5: The stored length is the count of bytes received between start and end, which includes the 4 trailing CRC bytes.
- R6: The next-page link equals the page following the frame's last stored byte, with wrap. This is the first page advanced ceil((len+4)/256) times.
- R7: The current page changes only in the cycle after the last header write, or on a select-0 configuration write. It never changes while a header is being written.
- R8: A frame is dropped if any page in the range first+1 through first+ceil((len+4)/256) (wrapped) equals the boundary at the time it is claimed. A dropped frame raises exactly one single-cycle overwrite pulse, writes no header, writes no further payload, and leaves the current page unchanged.
- R9: Payload bytes offered while no frame is open produce no memory write and no change to the current page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 start page, 1 end page, 2 boundary page |
| cfg_wdata | input | 8 | Configuration write data (page number) |
| cur_page | output | 8 | Current page pointer for the host to read |
| rx_start | input | 1 | Opens a frame |
| rx_valid | input | 1 | Payload byte valid |
| rx_data | input | 8 | Payload byte |
| rx_end | input | 1 | Closes the frame |
| rx_status | input | 8 | Receive status, sampled with rx_end |
| mem_addr | output | 16 | Local memory byte address (page, offset) |
| mem_wdata | output | 8 | Local memory write data |
| mem_we | output | 1 | Local memory write enable |
| ovw_evt | output | 1 | Single-cycle overwrite warning |

## Verification
The assertions assume a consistent ring configuration: the start page is below the end page and the boundary lies inside the ring. Configuration is never changed while a frame is open. They also assume that rx_end arrives in a cycle without rx_valid and that rx_start is raised only when the block is idle. The bench writes the configuration and boundary only between frames, keeps the ring at pages 2 to 7, and spaces each frame's strobes and bytes one per cycle. Under these conditions the data address range check and the current-page hold check are meaningful.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  localparam int PG_W   = 8;
  localparam int LEN_W  = 16;
  localparam int HDR_SZ = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_DROP, ST_HDR} wr_state_e;

  localparam logic [1:0] SEL_START = 2'd0;
  localparam logic [1:0] SEL_STOP  = 2'd1;
  localparam logic [1:0] SEL_BNRY  = 2'd2;

  // page that follows p inside the ring [first, stop)
  function automatic logic [PG_W-1:0] page_after(input logic [PG_W-1:0] p,
                                                 input logic [PG_W-1:0] first,
                                                 input logic [PG_W-1:0] stop);
    return (p == stop - 1'b1) ? first : p + 1'b1;
  endfunction
endpackage

// File: rtl/rxring_cfg.sv
module rxring_cfg
  import rxring_pkg::*;
#(
  parameter logic [PG_W-1:0] RST_START = 8'h40,
  parameter logic [PG_W-1:0] RST_STOP  = 8'h80
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [1:0]      sel,
  input  logic [PG_W-1:0] wdata,
  output logic [PG_W-1:0] pstart,
  output logic [PG_W-1:0] pstop,
  output logic [PG_W-1:0] bnry,
  output logic            start_wr
);
  assign start_wr = wr && (sel == SEL_START);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pstart <= RST_START;
      pstop  <= RST_STOP;
      bnry   <= RST_STOP - 1'b1;
    end else if (wr) begin
      case (sel)
        SEL_START: pstart <= wdata;
        SEL_STOP: begin
          pstop <= wdata;
          bnry  <= wdata - 1'b1;
        end
        SEL_BNRY: bnry <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rxring_writer.sv
module rxring_writer
  import rxring_pkg::*;
#(
  parameter logic [PG_W-1:0] RST_START = 8'h40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PG_W-1:0]      pstart,
  input  logic [PG_W-1:0]      pstop,
  input  logic [PG_W-1:0]      bnry,
  input  logic                 start_wr,
  input  logic [PG_W-1:0]      start_val,
  input  logic                 rx_start,
  input  logic                 rx_valid,
  input  logic [7:0]           rx_data,
  input  logic                 rx_end,
  input  logic [7:0]           rx_status,
  output logic [PG_W+7:0]      mem_addr,
  output logic [7:0]           mem_wdata,
  output logic                 mem_we,
  output logic                 ovw,
  output logic [PG_W-1:0]      cur_page
);
  wr_state_e        state;
  logic [PG_W-1:0]  cur_q, wr_page, next_q;
  logic [7:0]       wr_ofs, status_q;
  logic [LEN_W-1:0] byte_cnt;
  logic [1:0]       hdr_idx;

  // named internal events
  logic            data_we, at_cross, cross_full, end_evt, end_full, hdr_we, hdr_last;
  logic [PG_W-1:0] cross_page, end_next;

  assign data_we    = (state == ST_DATA) && rx_valid && !rx_end;
  assign at_cross   = data_we && (wr_ofs == 8'hFF);
  assign cross_page = page_after(wr_page, pstart, pstop);
  assign cross_full = at_cross && (cross_page == bnry);
  assign end_evt    = (state == ST_DATA) && rx_end;
  assign end_next   = (wr_ofs == 8'h00) ? wr_page : cross_page;
  assign end_full   = end_evt && (end_next == bnry);
  assign hdr_we     = (state == ST_HDR);
  assign hdr_last   = hdr_we && (hdr_idx == 2'd3);

  assign ovw      = cross_full || end_full;
  assign mem_we   = data_we || hdr_we;
  assign mem_addr = hdr_we ? {cur_q, 6'd0, hdr_idx} : {wr_page, wr_ofs};
  assign cur_page = cur_q;

  always_comb begin
    if (!hdr_we) mem_wdata = rx_data;
    else begin
      case (hdr_idx)
        2'd0:    mem_wdata = status_q;
        2'd1:    mem_wdata = next_q;
        2'd2:    mem_wdata = byte_cnt[7:0];
        default: mem_wdata = byte_cnt[15:8];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_q    <= RST_START;
      wr_page  <= RST_START;
      wr_ofs   <= 8'(HDR_SZ);
      next_q   <= RST_START;
      status_q <= 8'h00;
      byte_cnt <= '0;
      hdr_idx  <= 2'd0;
    end else begin
      if (start_wr) cur_q <= start_val;
      else if (hdr_last) cur_q <= next_q;
      case (state)
        ST_IDLE: if (rx_start) begin
          wr_page  <= cur_q;
          wr_ofs   <= 8'(HDR_SZ);
          byte_cnt <= '0;
          state    <= ST_DATA;
        end
        ST_DATA: begin
          if (rx_end) begin
            if (end_full) state <= ST_IDLE;
            else begin
              next_q   <= end_next;
              status_q <= rx_status;
              hdr_idx  <= 2'd0;
              state    <= ST_HDR;
            end
          end else if (data_we) begin
            byte_cnt <= byte_cnt + 1'b1;
            wr_ofs   <= wr_ofs + 1'b1;
            if (at_cross) begin
              if (cross_full) state <= ST_DROP;
              else wr_page <= cross_page;
            end
          end
        end
        ST_DROP: if (rx_end) state <= ST_IDLE;
        default: begin
          hdr_idx <= hdr_idx + 1'b1;
          if (hdr_last) state <= ST_IDLE;
        end
      endcase
    end
  end

  // R7: pointer moves only after the header is complete or on a start-page write
  p_cur_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hdr_last && !start_wr) |=> $stable(cur_q));
  // R8: a dropped frame writes nothing more
  p_drop_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DROP) |-> !mem_we);
  // R8: the warning is a single pulse
  p_ovw_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovw |=> !ovw);
  // R4: header lands in the frame's first page, in sequence
  p_hdr_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_we |-> (mem_addr[PG_W+7:8] == cur_q));
  p_hdr_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_we && hdr_idx != 2'd3) |=> (hdr_we && hdr_idx == $past(hdr_idx) + 2'd1));
  // R3: payload stays inside the ring
  p_data_in_ring_r3: assert property (@(posedge clk) disable iff (!rst_n)
    data_we |-> (wr_page >= pstart && wr_page < pstop));
  // R9: nothing is written while idle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !mem_we);
endmodule

// File: rtl/rxring_top.sv
module rxring_top
  import rxring_pkg::*;
#(
  parameter logic [7:0] RST_START = 8'h40,
  parameter logic [7:0] RST_STOP  = 8'h80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [1:0]  cfg_sel,
  input  logic [7:0]  cfg_wdata,
  output logic [7:0]  cur_page,
  input  logic        rx_start,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_end,
  input  logic [7:0]  rx_status,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  output logic        ovw_evt
);
  logic [PG_W-1:0] pstart, pstop, bnry;
  logic            start_wr;

  rxring_cfg #(.RST_START(RST_START), .RST_STOP(RST_STOP)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel), .wdata(cfg_wdata),
    .pstart(pstart), .pstop(pstop), .bnry(bnry), .start_wr(start_wr));

  rxring_writer #(.RST_START(RST_START)) u_wr (
    .clk(clk), .rst_n(rst_n), .pstart(pstart), .pstop(pstop), .bnry(bnry),
    .start_wr(start_wr), .start_val(cfg_wdata),
    .rx_start(rx_start), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_end(rx_end), .rx_status(rx_status),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .ovw(ovw_evt), .cur_page(cur_page));
endmodule

// File: tb/rxring_top_bench.sv
module rxring_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cur_page;
  logic rx_start = 1'b0, rx_valid = 1'b0, rx_end = 1'b0;
  logic [7:0] rx_data = 8'h00, rx_status = 8'h00;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata;
  logic mem_we, ovw_evt;

  int checks = 0, failures = 0;
  int wcnt = 0, ocnt = 0;
  logic [7:0] bmem [2048];

  localparam int RING_LO = 2, RING_HI = 8;

  // len, status, boundary, expect drop, expected current page afterwards
  typedef struct packed {
    logic [15:0] len; logic [7:0] st; logic [7:0] bn; logic drop; logic [7:0] cur;
  } vec_t;
  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{16'd60,   8'h01, 8'd7, 1'b0, 8'd3},
    '{16'd252,  8'h21, 8'd7, 1'b0, 8'd4},
    '{16'd300,  8'h03, 8'd7, 1'b0, 8'd6},
    '{16'd400,  8'h01, 8'd7, 1'b1, 8'd6},
    '{16'd400,  8'h01, 8'd3, 1'b0, 8'd2},
    '{16'd60,   8'h01, 8'd5, 1'b0, 8'd3},
    '{16'd260,  8'h01, 8'd5, 1'b1, 8'd3},
    '{16'd1000, 8'h80, 8'd2, 1'b0, 8'd7},
    '{16'd0,    8'h10, 8'd6, 1'b0, 8'd2}
  };

  rxring_top u_rxring_top (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cur_page(cur_page), .rx_start(rx_start),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_end(rx_end),
    .rx_status(rx_status), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .ovw_evt(ovw_evt));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) begin
      bmem[mem_addr[10:0]] <= mem_wdata;
      wcnt <= wcnt + 1;
    end
    if (ovw_evt) ocnt <= ocnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  function automatic int ring_addr(input int first, input int o);
    int pg = RING_LO + ((first - RING_LO) + o / 256) % (RING_HI - RING_LO);
    return pg * 256 + o % 256;
  endfunction

  task automatic send_frame(input int len, input logic [7:0] st, input logic [7:0] base,
                            input logic [7:0] old, input bit keep_check);
    @(negedge clk); rx_start = 1'b1;
    @(negedge clk); rx_start = 1'b0;
    for (int i = 0; i < len; i++) begin
      rx_valid = 1'b1; rx_data = base + 8'(i);
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_end = 1'b1; rx_status = st;
    @(negedge clk); rx_end = 1'b0;
    @(negedge clk);
    if (keep_check) chk(cur_page == old, "R7 cur held during header", cur_page, old);
    repeat (6) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [7:0] old;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cur_page == 8'h40, "R1 reset cur", cur_page, 8'h40);
    chk(wcnt == 0, "R1 no writes in reset", wcnt, 0);
    chk(ocnt == 0, "R1 no ovw in reset", ocnt, 0);

    cfg_write(2'd0, 8'(RING_LO));
    chk(cur_page == 8'(RING_LO), "R2 start write loads cur", cur_page, RING_LO);
    cfg_write(2'd1, 8'(RING_HI));

    // R9: bytes with no open frame
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_data = 8'hEE;
    end
    @(negedge clk); rx_valid = 1'b0;
    @(negedge clk);
    chk(wcnt == 0, "R9 idle bytes not written", wcnt, 0);
    chk(cur_page == 8'(RING_LO), "R9 idle cur unchanged", cur_page, RING_LO);

    for (int v = 0; v < NV; v++) begin
      int len, a;
      logic [7:0] base;
      len = int'(VECS[v].len);
      base = 8'(v * 37 + 5);
      cfg_write(2'd2, VECS[v].bn);
      old = cur_page;
      @(negedge clk); ocnt = 0;
      send_frame(len, VECS[v].st, base, old, !VECS[v].drop);
      chk(cur_page == VECS[v].cur, "R6/R8 cur after frame", cur_page, VECS[v].cur);
      chk(ocnt == (VECS[v].drop ? 1 : 0), "R8 ovw count", ocnt, VECS[v].drop ? 1 : 0);
      if (!VECS[v].drop) begin
        a = int'(old) * 256;
        chk(bmem[a[10:0]] == VECS[v].st, "R4 header status", bmem[a[10:0]], VECS[v].st);
        a = a + 1;
        chk(bmem[a[10:0]] == VECS[v].cur, "R6 header next link", bmem[a[10:0]], VECS[v].cur);
        a = a + 1;
        chk(bmem[a[10:0]] == VECS[v].len[7:0], "R5 length low", bmem[a[10:0]], VECS[v].len[7:0]);
        a = a + 1;
        chk(bmem[a[10:0]] == VECS[v].len[15:8], "R5 length high", bmem[a[10:0]], VECS[v].len[15:8]);
        if (len > 0) begin
          a = ring_addr(int'(old), 4 + len - 1);
          chk(bmem[a[10:0]] == base + 8'(len - 1), "R3 last payload byte",
              bmem[a[10:0]], base + 8'(len - 1));
          a = ring_addr(int'(old), 4);
          chk(bmem[a[10:0]] == base, "R3 first payload byte", bmem[a[10:0]], base);
        end
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule